// File: doc/BRIEF.md
# Round-Robin Scrub Ownership Controller

This block sits beside a group of processor cores that take turns sweeping the device configuration memory for upsets. It holds a token that names the one core currently doing that work. It sends that core a single-cycle start interrupt and then runs a countdown watchdog. Only the token holder can reload the watchdog.

When the holder reports that its sweep and its self-test are complete, the token moves to the next core in round-robin order, and that core gets its own start interrupt. If the countdown reaches zero first, the holder is presumed faulty. It is marked failed, the token moves on, and the next healthy core is started so that it can repair the fault. Failed cores are skipped in later rotations.

The block also grants exclusive access to the shared configuration port. It requests a full reconfiguration of the device in two cases: when no healthy core is left, or when the holder reports an error it cannot correct.

Top module: `scrub_master`

## Requirements
- R1: While reset is high, `owner_o` is 0 and all outputs and flags are clear. On the first clock edge after reset falls, `start_irq_o` pulses bit 0 for one cycle and the watchdog is loaded with `WDT_RELOAD`.
- R2: `start_irq_o` has at most one bit set. A set bit always equals the core that now holds the token, and it lasts one cycle for each token move.
- R3: A `done_i` pulse from the holder moves the token at that edge to the next core in increasing index order (wrapping from N_CORES-1 to 0) that is not marked failed. The new holder's start interrupt is raised, and the watchdog reloads.
- R4: A `kick_i` pulse from the holder reloads the watchdog to `WDT_RELOAD`. After a reload at edge k, with no further kick or done, the timeout takes effect at edge k+WDT_RELOAD+1.
- R5: On a timeout, the holder's bit in `failed_o` is set permanently. The token moves to the next core that is not failed, and that core's start interrupt is raised.
- R6: Cores marked failed are skipped by later token moves, and the holder is never a failed core unless a reconfiguration is requested.
- R7: A `kick_i`, `done_i` or `uncorr_i` pulse from a core other than the holder has no effect on the token, the watchdog or the reconfiguration request. It sets the sticky `proto_err_o`.
- R8: `lock_grant_o` has at most one bit set. A grant is issued only to the token holder while it requests and the port is free. The grant is kept until that core pulses `lock_rel_i`, even after the token has moved on by `done_i`.
- R9: A timeout withdraws any outstanding grant at the same edge.
- R10: When a timeout finds no core left that is not failed, `reconfig_req_o` is raised and stays high until reset.
- R11: An `uncorr_i` pulse from the holder raises `reconfig_req_o`.
- R12: While `reconfig_req_o` is high, no start interrupt or grant is issued, the token does not move, and no further core is marked failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | N_CORES | Per-core watchdog reload pulse |
| done_i | input | N_CORES | Per-core sweep-and-self-test complete pulse |
| uncorr_i | input | N_CORES | Per-core uncorrectable-error report pulse |
| lock_req_i | input | N_CORES | Per-core configuration port request level |
| lock_rel_i | input | N_CORES | Per-core configuration port release pulse |
| start_irq_o | output | N_CORES | One-cycle start interrupt to the new token holder |
| owner_o | output | $clog2(N_CORES) | Index of the token holder |
| lock_grant_o | output | N_CORES | One-hot configuration port grant |
| failed_o | output | N_CORES | Sticky per-core failed marks |
| proto_err_o | output | 1 | Sticky flag: a pulse came from a core that does not hold the token |
| reconfig_req_o | output | 1 | Sticky full-reconfiguration request |

## Verification
The token is driven in several ways, and each one separates different faults:
- A clean rotation driven only by completion pulses checks ordering and wrap-around.
- A holder that keeps kicking, then goes silent, pins the timeout to the exact edge and so exposes an off-by-one in the reload value.
- A single timeout followed by completions shows that a failed core is skipped.
- Timing out every core in turn reaches the reconfiguration request.

The lock sequences separate the two ways a grant ends: a voluntary release, and a forced withdrawal at a timeout. They also show that a grant outlives a completion hand-off. Pulses from cores that do not hold the token are mixed in while the watchdog runs, so that a design accepting them is caught either by a changed timeout edge or by a moved token.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    // Upper bound on the core count supported by the search helper.
    localparam int MAX_CORES = 32;

    // What the token logic does on a given cycle.
    typedef enum logic [1:0] {
        TEV_NONE    = 2'd0,
        TEV_PASS    = 2'd1,
        TEV_TIMEOUT = 2'd2,
        TEV_FATAL   = 2'd3
    } tok_ev_e;

    // Pulses received from the current token holder, already qualified.
    typedef struct packed {
        logic kick;
        logic done;
        logic uncorr;
    } holder_ev_t;

    // Search forward from cur (exclusive, wrapping) for a core whose skip
    // bit is clear. Returns -1 when none exists among the first n cores.
    function automatic int next_core(input int cur,
                                     input logic [MAX_CORES-1:0] skip,
                                     input int n);
        int res;
        int c;
        res = -1;
        for (int k = 1; k <= MAX_CORES; k++) begin
            if (k <= n && res < 0) begin
                c = (cur + k) % n;
                if (!skip[c]) res = c;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/scrub_wdt.sv
module scrub_wdt #(
    parameter int RELOAD = 16,
    parameter int CW     = $clog2(RELOAD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic reload_i,
    input  logic hold_i,
    output logic expired_o
);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RELOAD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= LOAD_VAL;
        end else if (hold_i) begin
            cnt_q <= cnt_q;
        end else if (reload_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/scrub_token.sv
module scrub_token
    import scrub_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int IDW     = $clog2(N_CORES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CORES-1:0] kick_i,
    input  logic [N_CORES-1:0] done_i,
    input  logic [N_CORES-1:0] uncorr_i,
    input  logic               expired_i,
    output logic [IDW-1:0]     owner_o,
    output logic [N_CORES-1:0] irq_o,
    output logic [N_CORES-1:0] failed_o,
    output logic               reconf_o,
    output logic               proto_err_o,
    output logic               wdt_reload_o,
    output logic               lock_clr_o
);
    logic [IDW-1:0]     owner_q;
    logic [N_CORES-1:0] failed_q;
    logic [N_CORES-1:0] irq_q;
    logic               reconf_q;
    logic               boot_q;
    logic               perr_q;

    logic [N_CORES-1:0] own_oh;
    logic               active;
    holder_ev_t         hev;
    tok_ev_e            ev;
    logic               foreign;
    int                 pass_nx;
    int                 to_nx;

    assign own_oh = {{(N_CORES-1){1'b0}}, 1'b1} << owner_q;
    assign active = !boot_q && !reconf_q;

    always_comb begin
        hev.kick   = active && kick_i[owner_q];
        hev.done   = active && done_i[owner_q];
        hev.uncorr = active && uncorr_i[owner_q];
    end

    assign foreign = |((kick_i | done_i | uncorr_i) & ~own_oh);

    // Candidates for the next holder: on a hand-off the holder may keep the
    // token if it is the only healthy core; on a timeout it may not.
    always_comb begin
        pass_nx = next_core(int'(owner_q), MAX_CORES'(failed_q), N_CORES);
        to_nx   = next_core(int'(owner_q), MAX_CORES'(failed_q | own_oh), N_CORES);
    end

    always_comb begin
        ev = TEV_NONE;
        if (hev.uncorr)                      ev = TEV_FATAL;
        else if (hev.done)                   ev = TEV_PASS;
        else if (!hev.kick && active && expired_i) ev = TEV_TIMEOUT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q  <= '0;
            failed_q <= '0;
            irq_q    <= '0;
            reconf_q <= 1'b0;
            boot_q   <= 1'b1;
            perr_q   <= 1'b0;
        end else begin
            boot_q <= 1'b0;
            irq_q  <= boot_q ? own_oh : '0;
            if (foreign) perr_q <= 1'b1;
            unique case (ev)
                TEV_PASS: begin
                    owner_q <= IDW'(pass_nx);
                    irq_q   <= {{(N_CORES-1){1'b0}}, 1'b1} << pass_nx;
                end
                TEV_TIMEOUT: begin
                    failed_q <= failed_q | own_oh;
                    if (to_nx >= 0) begin
                        owner_q <= IDW'(to_nx);
                        irq_q   <= {{(N_CORES-1){1'b0}}, 1'b1} << to_nx;
                    end else begin
                        reconf_q <= 1'b1;
                    end
                end
                TEV_FATAL: reconf_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign wdt_reload_o = boot_q || hev.kick || (ev == TEV_PASS) ||
                          (ev == TEV_TIMEOUT && to_nx >= 0);
    assign lock_clr_o   = reconf_q || (ev == TEV_TIMEOUT) || (ev == TEV_FATAL);

    assign owner_o     = owner_q;
    assign irq_o       = irq_q;
    assign failed_o    = failed_q;
    assign reconf_o    = reconf_q;
    assign proto_err_o = perr_q;
endmodule

// File: rtl/scrub_lock.sv
module scrub_lock #(
    parameter int N_CORES = 4,
    parameter int IDW     = $clog2(N_CORES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDW-1:0]     owner_i,
    input  logic [N_CORES-1:0] req_i,
    input  logic [N_CORES-1:0] rel_i,
    input  logic               clr_i,
    output logic [N_CORES-1:0] grant_o
);
    logic           held_q;
    logic [IDW-1:0] gid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            gid_q  <= '0;
        end else if (clr_i) begin
            held_q <= 1'b0;
        end else if (held_q) begin
            if (rel_i[gid_q]) held_q <= 1'b0;
        end else if (req_i[owner_i]) begin
            held_q <= 1'b1;
            gid_q  <= owner_i;
        end
    end

    assign grant_o = held_q ? ({{(N_CORES-1){1'b0}}, 1'b1} << gid_q) : '0;
endmodule

// File: rtl/scrub_master.sv
module scrub_master
    import scrub_pkg::*;
#(
    parameter int N_CORES    = 4,
    parameter int WDT_RELOAD = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_CORES-1:0]         kick_i,
    input  logic [N_CORES-1:0]         done_i,
    input  logic [N_CORES-1:0]         uncorr_i,
    input  logic [N_CORES-1:0]         lock_req_i,
    input  logic [N_CORES-1:0]         lock_rel_i,
    output logic [N_CORES-1:0]         start_irq_o,
    output logic [$clog2(N_CORES)-1:0] owner_o,
    output logic [N_CORES-1:0]         lock_grant_o,
    output logic [N_CORES-1:0]         failed_o,
    output logic                       proto_err_o,
    output logic                       reconfig_req_o
);
    localparam int IDW = $clog2(N_CORES);
    localparam int CW  = $clog2(WDT_RELOAD + 1);

    logic           expired;
    logic           wdt_reload;
    logic           lock_clr;
    logic [IDW-1:0] owner;
    logic           reconf;

    scrub_wdt #(.RELOAD(WDT_RELOAD), .CW(CW)) u_wdt (
        .clk       (clk),
        .rst       (rst),
        .reload_i  (wdt_reload),
        .hold_i    (reconf),
        .expired_o (expired)
    );

    scrub_token #(.N_CORES(N_CORES), .IDW(IDW)) u_token (
        .clk          (clk),
        .rst          (rst),
        .kick_i       (kick_i),
        .done_i       (done_i),
        .uncorr_i     (uncorr_i),
        .expired_i    (expired),
        .owner_o      (owner),
        .irq_o        (start_irq_o),
        .failed_o     (failed_o),
        .reconf_o     (reconf),
        .proto_err_o  (proto_err_o),
        .wdt_reload_o (wdt_reload),
        .lock_clr_o   (lock_clr)
    );

    scrub_lock #(.N_CORES(N_CORES), .IDW(IDW)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .owner_i (owner),
        .req_i   (lock_req_i),
        .rel_i   (lock_rel_i),
        .clr_i   (lock_clr),
        .grant_o (lock_grant_o)
    );

    assign owner_o        = owner;
    assign reconfig_req_o = reconf;
endmodule

// File: rtl/scrub_master_chk.sv
module scrub_master_chk #(
    parameter int N_CORES = 4,
    parameter int IDW     = $clog2(N_CORES)
) (
    input logic               clk,
    input logic               rst,
    input logic [N_CORES-1:0] lock_req_i,
    input logic [N_CORES-1:0] start_irq_o,
    input logic [IDW-1:0]     owner_o,
    input logic [N_CORES-1:0] lock_grant_o,
    input logic [N_CORES-1:0] failed_o,
    input logic               proto_err_o,
    input logic               reconfig_req_o
);
    assert_irq_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_irq_o));

    assert_irq_owner_R2: assert property (@(posedge clk) disable iff (rst)
        (start_irq_o != '0) |-> start_irq_o[owner_o]);

    assert_failed_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ((failed_o & $past(failed_o)) == $past(failed_o)));

    assert_owner_healthy_R6: assert property (@(posedge clk) disable iff (rst)
        !reconfig_req_o |-> !failed_o[owner_o]);

    assert_perr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |=> proto_err_o);

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lock_grant_o));

    assert_grant_requested_R8: assert property (@(posedge clk) disable iff (rst)
        ((lock_grant_o != '0) && ($past(lock_grant_o) == '0))
            |-> (($past(lock_req_i) & lock_grant_o) != '0));

    assert_reconf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        reconfig_req_o |=> reconfig_req_o);

    assert_reconf_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        reconfig_req_o |-> (start_irq_o == '0 && lock_grant_o == '0));

    assert_reconf_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        reconfig_req_o |=> ($stable(owner_o) && $stable(failed_o)));
endmodule

bind scrub_master scrub_master_chk #(.N_CORES(N_CORES), .IDW(IDW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .lock_req_i     (lock_req_i),
    .start_irq_o    (start_irq_o),
    .owner_o        (owner_o),
    .lock_grant_o   (lock_grant_o),
    .failed_o       (failed_o),
    .proto_err_o    (proto_err_o),
    .reconfig_req_o (reconfig_req_o)
);

// File: tb/scrub_master_bench.sv
module scrub_master_bench;
    localparam int N  = 4;
    localparam int RL = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] kick = '0, done = '0, unc = '0, lreq = '0, lrel = '0;
    logic [N-1:0] irq, grant, failed;
    logic [1:0]   owner;
    logic         perr, reconf;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    scrub_master #(.N_CORES(N), .WDT_RELOAD(RL)) u_scrub_master (
        .clk(clk), .rst(rst), .kick_i(kick), .done_i(done), .uncorr_i(unc),
        .lock_req_i(lreq), .lock_rel_i(lrel), .start_irq_o(irq),
        .owner_o(owner), .lock_grant_o(grant), .failed_o(failed),
        .proto_err_o(perr), .reconfig_req_o(reconf)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        kick = '0; done = '0; unc = '0; lreq = '0; lrel = '0;
        rst = 1'b1;
        step(3);
        check("R1 reset owner", int'(owner), 0);
        check("R1 reset irq", int'(irq), 0);
        check("R1 reset grant", int'(grant), 0);
        check("R1 reset flags", int'({failed, perr, reconf}), 0);
        rst = 1'b0;
        step(1);
        check("R1 boot irq", int'(irq), 1);
    endtask

    task automatic pulse_done(input int c);
        done[c] = 1'b1; step(1); done[c] = 1'b0;
    endtask

    task automatic pulse_kick(input int c);
        kick[c] = 1'b1; step(1); kick[c] = 1'b0;
    endtask

    task automatic pulse_unc(input int c);
        unc[c] = 1'b1; step(1); unc[c] = 1'b0;
    endtask

    task automatic t_rotation();
        do_reset();
        step(1);
        check("R2 irq one cycle", int'(irq), 0);
        pulse_done(0);
        check("R3 owner 0->1", int'(owner), 1);
        check("R3 irq 1", int'(irq), 2);
        step(1);
        check("R2 irq cleared", int'(irq), 0);
        pulse_done(1);
        check("R3 owner 1->2", int'(owner), 2);
        pulse_done(2);
        check("R3 owner 2->3", int'(owner), 3);
        pulse_done(3);
        check("R3 wrap owner 3->0", int'(owner), 0);
        check("R3 wrap irq 0", int'(irq), 1);
        check("R3 no perr", int'(perr), 0);
    endtask

    task automatic t_kick();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            step(10);
            pulse_kick(0);
        end
        check("R4 kicked holder kept", int'(owner), 0);
        check("R4 no failure", int'(failed), 0);
        step(RL);
        check("R4 before expiry", int'(owner), 0);
        step(1);
        check("R4 expiry edge", int'(owner), 1);
    endtask

    task automatic t_foreign();
        do_reset();
        pulse_done(2);
        check("R7 foreign done ignored", int'(owner), 0);
        check("R7 perr set", int'(perr), 1);
        check("R7 no irq", int'(irq), 0);
        step(5);
        pulse_kick(1);
        pulse_unc(3);
        check("R7 foreign uncorr ignored", int'(reconf), 0);
        step(RL - 8);
        check("R7 foreign kick no reload", int'(owner), 0);
        step(1);
        check("R7 timeout on schedule", int'(owner), 1);
        check("R7 perr sticky", int'(perr), 1);
    endtask

    task automatic t_skip();
        do_reset();
        step(RL);
        check("R5 not yet", int'(failed), 0);
        step(1);
        check("R5 failed mark", int'(failed), 1);
        check("R5 owner moved", int'(owner), 1);
        check("R5 irq next", int'(irq), 2);
        pulse_done(1);
        pulse_done(2);
        pulse_done(3);
        check("R6 skip failed core", int'(owner), 1);
        check("R6 irq skip", int'(irq), 2);
    endtask

    task automatic t_lock();
        do_reset();
        lreq[1] = 1'b1; step(1);
        check("R8 non-holder denied", int'(grant), 0);
        lreq[1] = 1'b0; lreq[0] = 1'b1; step(1);
        check("R8 holder granted", int'(grant), 1);
        lreq[0] = 1'b0; step(1);
        check("R8 grant held", int'(grant), 1);
        lrel[0] = 1'b1; step(1); lrel[0] = 1'b0;
        check("R8 released", int'(grant), 0);
        lreq[0] = 1'b1; step(1); lreq[0] = 1'b0;
        check("R8 regrant", int'(grant), 1);
        step(11);
        check("R9 held before timeout", int'(grant), 1);
        step(1);
        check("R9 timeout clears grant", int'(grant), 0);
        check("R9 owner moved", int'(owner), 1);
        lreq[1] = 1'b1; step(1); lreq[1] = 1'b0;
        check("R8 new holder granted", int'(grant), 2);
        pulse_done(1);
        check("R8 grant outlives pass", int'(grant), 2);
        lreq[2] = 1'b1; step(1);
        check("R8 exclusive while held", int'(grant), 2);
        lrel[1] = 1'b1; step(1); lrel[1] = 1'b0;
        check("R8 release by old holder", int'(grant), 0);
        step(1); lreq[2] = 1'b0;
        check("R8 grant to new holder", int'(grant), 4);
    endtask

    task automatic t_all_fail();
        do_reset();
        for (int c = 0; c < N - 1; c++) begin
            step(RL + 1);
            check("R5 chained timeout", int'(owner), c + 1);
        end
        check("R10 not yet", int'(reconf), 0);
        step(RL + 1);
        check("R10 all failed", int'(failed), 15);
        check("R10 reconfig raised", int'(reconf), 1);
        check("R12 no irq", int'(irq), 0);
        step(5);
        check("R10 sticky", int'(reconf), 1);
        check("R12 quiet irq", int'(irq), 0);
    endtask

    task automatic t_uncorr();
        do_reset();
        lreq[0] = 1'b1; step(1); lreq[0] = 1'b0;
        check("R11 setup grant", int'(grant), 1);
        pulse_unc(0);
        check("R11 reconfig raised", int'(reconf), 1);
        check("R12 grant withdrawn", int'(grant), 0);
        pulse_done(0);
        check("R12 token frozen", int'(owner), 0);
        check("R12 no irq", int'(irq), 0);
        lreq[0] = 1'b1; step(1); lreq[0] = 1'b0;
        check("R12 no grant", int'(grant), 0);
        step(RL + 5);
        check("R12 no new failures", int'(failed), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_rotation();
        t_kick();
        t_foreign();
        t_skip();
        t_lock();
        t_all_fail();
        t_uncorr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule